// File: doc/BRIEF.md
# Programmable Interval Timer Core

This block gives a host three independent 16-bit down counters behind a small 8-bit register port. Each counter has its own count clock, an enable (gate) input and an active-low output. The host first writes a control word that picks a counter, the byte order used to reach its 16-bit count, and whether it counts in plain binary or in four-digit BCD. The host then loads an initial count, one or two bytes. From then on every rising edge of that counter's count clock, while its gate is high, takes one off the count. When the count stands at one the output drops for one count-clock period, and the next edge reloads the initial count. The counter therefore divides its count clock by the loaded value and runs on until it is reprogrammed.

The host can read any counter while it runs, either live or through a latch command. The latch command freezes a snapshot that later reads return until every byte of it has been read. Count clocks are sampled in the system clock domain, so they must be slower than the system clock. Every bus access lasts exactly one system clock cycle with its strobe low.

Top module: `pit_core`

## Requirements
- R1: With `cs_n` low, `wr_n` low and `rd_n` high, a write is made. With `cs_n` low, `rd_n` low and `wr_n` high, a read is made. `addr` 0, 1 and 2 reach counters 0 to 2, and `addr` 3 reaches the control word. A write with `cs_n` high has no effect. `dout` is 0x00 whenever no counter is being read, and that includes a read of `addr` 3.
- R2: Control word fields: bits [7:6] pick the counter, and the value 3 selects none, so the word is ignored. Bits [5:4] give the access: 0 latches the count, 1 selects the low byte only, 2 the high byte only, 3 the low byte then the high byte. Bit 0 set selects BCD. A word with a non-zero access stops the counter until a count is loaded, clears the byte toggles and drops any latch.
- R3: In low-only access a written byte loads count {0x00, byte}. In high-only access it loads {byte, 0x00}. In low-then-high access the first write holds the low byte and the second loads the full count. The count takes the new value in the cycle after the last byte is written, and counting starts from it.
- R4: In binary format each counted edge decrements by one, and 0x0000 goes to 0xFFFF.
- R5: In BCD format each counted edge decrements by one in decimal, with a borrow across digits, and 0x0000 goes to 0x9999.
- R6: While a counter's gate is low, its count does not change.
- R7: A counter's output is high, except while the counter is running and its count equals 1. The edge counted at a count of 1 reloads the initial count.
- R8: A live read returns the low byte or the high byte of the current count and does not change it. In low-then-high access, successive reads alternate, starting with the low byte.
- R9: A latch command copies the current count into a holding register. Reads then return the held bytes until all of them have been read: two reads in low-then-high access, one read otherwise. A latch command given while a value is still held is ignored.
- R10: Each rising edge of a count clock is counted exactly once, no matter how long the clock stays high, and the count changes within four system clock cycles of the edge.
- R11: After reset every count is 0, every output is high, every counter is stopped, and every counter is set to low-then-high access in binary format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0x00 when no counter is read |
| cnt_clk | input | 3 | Count clock of each counter |
| cnt_gate | input | 3 | Counting enable of each counter |
| cnt_out | output | 3 | Active-low terminal pulse of each counter |

## Verification
A table of vectors loads counter 0 with different starting values in both formats, applies a number of count edges and reads the result back through a latch. Values that borrow across BCD digits, the wrap from zero in each format and the reload at a count of one are what separate a correct decrementer from a nearly correct one. Directed tests then cover each access order, the byte toggle being cleared by a control word, the gate hold, the output pulse, and a latch that outlives later count edges and ignores a second latch command. Chip-select masking and a long-held count clock are also covered.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_CNT_W  = 16;
    localparam int PIT_BYTE_W = 8;
    localparam int PIT_NUM_CH = 3;
    localparam int PIT_ADDR_W = 2;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e acc;
        logic bcd;
    } chan_cfg_t;

    function automatic logic [PIT_CNT_W-1:0] bcd_dec(input logic [PIT_CNT_W-1:0] v);
        logic [PIT_CNT_W-1:0] r;
        logic                 borrow;
        r      = v;
        borrow = 1'b1;
        for (int d = 0; d < PIT_CNT_W / 4; d++) begin
            if (borrow) begin
                if (r[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else begin
                    r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pit_edge_sync.sv
module pit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10: a detected edge lasts a single system cycle
    assert_single_tick_R10: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CNT_W  = PIT_CNT_W,
    parameter int BYTE_W = PIT_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_we,
    input  chan_cfg_t         cw_cfg,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cclk,
    input  logic              gate,
    output logic              cnt_out
);
    localparam int PAD_W = CNT_W - BYTE_W;

    chan_cfg_t         cfg_q;
    logic [CNT_W-1:0]  init_q, cnt_q, hold_q, dec_val, load_val, src;
    logic [BYTE_W-1:0] lsb_buf_q;
    logic              running_q, wr_tog_q, rd_tog_q, latched_q;
    logic              tick, load_now, at_one;

    pit_edge_sync #(.STAGES(2)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (cclk),
        .rise(tick)
    );

    assign at_one  = (cnt_q == CNT_W'(1));
    assign dec_val = cfg_q.bcd ? bcd_dec(cnt_q) : cnt_q - CNT_W'(1);

    always_comb begin
        load_now = 1'b0;
        load_val = init_q;
        if (wr_en) begin
            case (cfg_q.acc)
                ACC_LO: begin
                    load_now = 1'b1;
                    load_val = {{PAD_W{1'b0}}, wr_data};
                end
                ACC_HI: begin
                    load_now = 1'b1;
                    load_val = {wr_data, {PAD_W{1'b0}}};
                end
                ACC_LOHI: begin
                    if (wr_tog_q) begin
                        load_now = 1'b1;
                        load_val = {wr_data, lsb_buf_q};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{acc: ACC_LOHI, bcd: 1'b0};
            init_q    <= '0;
            cnt_q     <= '0;
            hold_q    <= '0;
            lsb_buf_q <= '0;
            running_q <= 1'b0;
            wr_tog_q  <= 1'b0;
            rd_tog_q  <= 1'b0;
            latched_q <= 1'b0;
        end else begin
            if (load_now) begin
                init_q    <= load_val;
                cnt_q     <= load_val;
                running_q <= 1'b1;
            end else if (tick && gate && running_q) begin
                cnt_q <= at_one ? init_q : dec_val;
            end

            if (wr_en && cfg_q.acc == ACC_LOHI) begin
                wr_tog_q <= ~wr_tog_q;
                if (!wr_tog_q) lsb_buf_q <= wr_data;
            end

            if (rd_en) begin
                if (cfg_q.acc == ACC_LOHI) begin
                    rd_tog_q <= ~rd_tog_q;
                    if (rd_tog_q) latched_q <= 1'b0;
                end else begin
                    latched_q <= 1'b0;
                end
            end

            if (cw_we) begin
                if (cw_cfg.acc == ACC_LATCH) begin
                    if (!latched_q) begin
                        hold_q    <= cnt_q;
                        latched_q <= 1'b1;
                        rd_tog_q  <= 1'b0;
                    end
                end else begin
                    cfg_q     <= cw_cfg;
                    running_q <= 1'b0;
                    wr_tog_q  <= 1'b0;
                    rd_tog_q  <= 1'b0;
                    latched_q <= 1'b0;
                end
            end
        end
    end

    assign src     = latched_q ? hold_q : cnt_q;
    assign rd_data = (cfg_q.acc == ACC_HI || (cfg_q.acc == ACC_LOHI && rd_tog_q))
                     ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
    assign cnt_out = ~(running_q && at_one);

    // R6: a low gate freezes the count unless a new count is loaded
    assert_gate_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!gate && !wr_en) |=> $stable(cnt_q));

    // R8: a read alone never moves the count
    assert_read_nodisturb_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !tick && !wr_en) |=> $stable(cnt_q));

    // R7: the edge counted at one brings back the initial count
    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && gate && running_q && !wr_en && at_one) |=> (cnt_q == $past(init_q)));

    // R9: a held value survives until read out or a new mode is written
    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (latched_q && !rd_en && !cw_we) |=> (latched_q && $stable(hold_q)));

endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int NUM_CH = PIT_NUM_CH,
    parameter int CNT_W  = PIT_CNT_W,
    parameter int BYTE_W = PIT_BYTE_W,
    parameter int ADDR_W = PIT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    input  logic [NUM_CH-1:0] cnt_clk,
    input  logic [NUM_CH-1:0] cnt_gate,
    output logic [NUM_CH-1:0] cnt_out
);
    localparam logic [ADDR_W-1:0] CW_ADDR = {ADDR_W{1'b1}};

    logic              wr_act, rd_act, cw_hit;
    logic [NUM_CH-1:0] cw_we, ctr_we, ctr_re;
    logic [BYTE_W-1:0] rd_bus [NUM_CH];
    chan_cfg_t         cw_cfg;
    logic              unused_mode_bits;

    assign wr_act = !cs_n && !wr_n && rd_n;
    assign rd_act = !cs_n && !rd_n && wr_n;
    assign cw_hit = wr_act && (addr == CW_ADDR);
    assign cw_cfg = '{acc: acc_e'(din[5:4]), bcd: din[0]};
    assign unused_mode_bits = ^din[3:1];

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            cw_we[i]  = cw_hit && (din[BYTE_W-1 -: ADDR_W] == ADDR_W'(i));
            ctr_we[i] = wr_act && (addr == ADDR_W'(i));
            ctr_re[i] = rd_act && (addr == ADDR_W'(i));
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pit_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) ctr_i (
                .clk    (clk),
                .rst    (rst),
                .cw_we  (cw_we[g]),
                .cw_cfg (cw_cfg),
                .wr_en  (ctr_we[g]),
                .wr_data(din),
                .rd_en  (ctr_re[g]),
                .rd_data(rd_bus[g]),
                .cclk   (cnt_clk[g]),
                .gate   (cnt_gate[g]),
                .cnt_out(cnt_out[g])
            );
        end
    endgenerate

    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ctr_re[i]) dout = rd_bus[i];
        end
    end

    // R1: one bus cycle reaches at most one target
    assert_one_target_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cw_we, ctr_we, ctr_re}));

endmodule

// File: tb/pit_core_tb_top.sv
module pit_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [2:0] cnt_clk = 3'b000;
    logic [2:0] cnt_gate = 3'b111;
    logic [2:0] cnt_out;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;
    logic [7:0]  rb, rb2;
    logic [15:0] rv;

    always #2 clk = ~clk;

    pit_core dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout),
        .cnt_clk(cnt_clk), .cnt_gate(cnt_gate), .cnt_out(cnt_out)
    );

    localparam int N_VEC = 8;
    localparam logic [15:0] V_INIT [N_VEC] = '{16'h0064, 16'h0000, 16'h0100, 16'h0000,
                                              16'h1000, 16'h0005, 16'h0003, 16'h0010};
    localparam logic        V_BCD  [N_VEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam int          V_EDGE [N_VEC] = '{3, 1, 1, 1, 3, 4, 3, 2};
    localparam logic [15:0] V_EXP  [N_VEC] = '{16'h0061, 16'hFFFF, 16'h0099, 16'h9999,
                                              16'h0997, 16'h0001, 16'h0003, 16'h0008};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; addr = a; rd_n = 1'b0;
        #1 d = dout;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic rd16(input logic [1:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(a, lo);
        bus_rd(a, hi);
        v = {hi, lo};
    endtask

    task automatic cpulse(input int ch);
        @(negedge clk);
        cnt_clk[ch] = 1'b1;
        repeat (4) @(negedge clk);
        cnt_clk[ch] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic setup_lohi(input logic [1:0] ch, input logic bcd, input logic [15:0] v);
        bus_wr(2'd3, {ch, 2'b11, 3'b000, bcd}, 1'b0);
        bus_wr(ch, v[7:0], 1'b0);
        bus_wr(ch, v[15:8], 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 outputs high after reset", {13'd0, cnt_out}, 16'h0007);
        bus_rd(2'd1, rb);
        check("R11 count zero after reset", {8'd0, rb}, 16'h0000);

        // R1 read of the control address returns zero
        bus_rd(2'd3, rb);
        check("R1 control address read", {8'd0, rb}, 16'h0000);

        // R4 R5 R7 vector table on counter 0
        for (int v = 0; v < N_VEC; v++) begin
            setup_lohi(2'd0, V_BCD[v], V_INIT[v]);
            for (int e = 0; e < V_EDGE[v]; e++) cpulse(0);
            bus_wr(2'd3, 8'h00, 1'b0);
            rd16(2'd0, rv);
            check(V_BCD[v] ? "R5 bcd vector" : "R4 binary vector", rv, V_EXP[v]);
        end

        // R3 R8 load and live read on counter 1
        setup_lohi(2'd1, 1'b0, 16'h1234);
        rd16(2'd1, rv);
        check("R3 low-then-high load", rv, 16'h1234);
        rd16(2'd1, rv);
        check("R8 repeated live read", rv, 16'h1234);

        // R1 writes with chip select high are dropped
        bus_wr(2'd1, 8'hFF, 1'b1);
        bus_wr(2'd1, 8'hFF, 1'b1);
        rd16(2'd1, rv);
        check("R1 deselected write ignored", rv, 16'h1234);

        // R6 gate low holds
        cnt_gate[1] = 1'b0;
        for (int e = 0; e < 3; e++) cpulse(1);
        rd16(2'd1, rv);
        check("R6 gate low holds count", rv, 16'h1234);
        cnt_gate[1] = 1'b1;
        cpulse(1);
        rd16(2'd1, rv);
        check("R4 count after gate reopens", rv, 16'h1233);

        // R10 long high count clock counted once, within four cycles
        @(negedge clk);
        cnt_clk[1] = 1'b1;
        repeat (3) @(negedge clk);
        rd16(2'd1, rv);
        check("R10 edge applied promptly", rv, 16'h1232);
        repeat (20) @(negedge clk);
        rd16(2'd1, rv);
        check("R10 held clock counted once", rv, 16'h1232);
        cnt_clk[1] = 1'b0;
        repeat (4) @(negedge clk);

        // R7 output pulse on counter 2
        setup_lohi(2'd2, 1'b0, 16'h0003);
        check("R7 output high while counting", {15'd0, cnt_out[2]}, 16'h0001);
        cpulse(2);
        cpulse(2);
        check("R7 output low at count one", {15'd0, cnt_out[2]}, 16'h0000);
        cpulse(2);
        check("R7 output high after reload", {15'd0, cnt_out[2]}, 16'h0001);
        rd16(2'd2, rv);
        check("R7 reload value", rv, 16'h0003);

        // R9 latch behaviour on counter 2
        setup_lohi(2'd2, 1'b0, 16'h0050);
        bus_wr(2'd3, 8'h80, 1'b0);
        cpulse(2);
        cpulse(2);
        rd16(2'd2, rv);
        check("R9 latched value read", rv, 16'h0050);
        rd16(2'd2, rv);
        check("R9 live after latch read out", rv, 16'h004E);
        bus_wr(2'd3, 8'h80, 1'b0);
        cpulse(2);
        bus_wr(2'd3, 8'h80, 1'b0);
        cpulse(2);
        rd16(2'd2, rv);
        check("R9 second latch ignored", rv, 16'h004E);
        rd16(2'd2, rv);
        check("R9 live count after release", rv, 16'h004C);

        // R3 low-only and high-only access on counter 0
        bus_wr(2'd3, 8'b00_01_0000, 1'b0);
        bus_wr(2'd0, 8'h34, 1'b0);
        bus_rd(2'd0, rb);
        bus_rd(2'd0, rb2);
        check("R3 low-only load and read", {rb2, rb}, 16'h3434);
        bus_wr(2'd3, 8'b00_10_0000, 1'b0);
        bus_wr(2'd0, 8'h12, 1'b0);
        bus_rd(2'd0, rb);
        check("R3 high-only read", {8'd0, rb}, 16'h0012);
        bus_wr(2'd3, 8'b00_11_0000, 1'b0);
        rd16(2'd0, rv);
        check("R3 high-only zero low byte", rv, 16'h1200);

        // R2 control word clears write toggle and stops counting
        bus_wr(2'd0, 8'hAA, 1'b0);
        setup_lohi(2'd0, 1'b0, 16'h5678);
        rd16(2'd0, rv);
        check("R2 toggle cleared by control word", rv, 16'h5678);
        bus_wr(2'd3, 8'b00_11_0000, 1'b0);
        cpulse(0);
        rd16(2'd0, rv);
        check("R2 control word stops counter", rv, 16'h5678);
        bus_wr(2'd3, 8'b11_01_0000, 1'b0);
        rd16(2'd0, rv);
        check("R2 select three ignored", rv, 16'h5678);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule